// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog reached through a small 32-bit register bus. A free-running tick enable, one pulse per microsecond, is supplied from outside. Each tick decrements a 32-bit count while the watchdog is enabled, so the longest period is just under 4295 seconds. Software keeps the watchdog alive by writing a fixed key value to a restart register. That write copies the programmed reload value into the count. Any other value written there is discarded.

When a tick arrives while the count is already zero, the watchdog expires. It reloads itself and carries on counting. On that expiry it can pulse a reset request and an external-pulse trigger, and it can latch an alternate-boot flag. The control word also holds a 20-bit early-warning threshold. When the count steps down onto the threshold, a sticky warning flag can raise an interrupt ahead of expiry. The reset scope code in the control word is driven straight out to the reset distribution logic, which lies outside this block.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the count reads 0, reload reads 0xFFFFFFFF, control and status read 0, and irq, rst_req, ext_pulse and alt_boot are low.
- R2: A write of 0x00004755 to byte offset 0x08 loads the count from the reload register on the next clock. A write of any other value there leaves the count unchanged.
- R3: While control bit 0 is 1, each cycle with tick_en high decrements a nonzero count by one. While control bit 0 is 0, the count holds. Writes to offset 0x00 are ignored.
- R4: A tick with control bit 0 set and the count at zero is an expiry. The count is loaded from reload, so one period is reload+1 ticks.
- R5: An expiry drives rst_req high for exactly the following cycle if control bit 1 is set. It drives ext_pulse high for exactly the following cycle if control bit 3 is set.
- R6: rst_scope always equals control bits 6:5 (00 SoC, 01 full chip, 10 CPU only). Control bit 4 (tick-source select) is stored and read back but does not change counting.
- R7: Control bits 31:12 form the warning threshold. If a decrement makes the count equal to that threshold while control bit 2 is set, status bit 2 and irq go high from the next cycle and stay high until cleared. With bit 2 clear, nothing is flagged.
- R8: An expiry with control bit 7 set raises status bit 1 and alt_boot, which stay high until cleared.
- R9: Writing a value with bit 0 set to offset 0x14 clears status bits 2 and 1. A value with bit 0 clear has no effect. If a flag is set in the same cycle as a clear, the set wins.
- R10: A keyed restart in the same cycle as an expiring tick takes priority. No expiry occurs, no pulse is issued, and the count equals reload.
- R11: Writing the reload register (offset 0x04) does not change the count until the next restart or expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per microsecond time base |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Early-warning interrupt (status bit 2) |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_scope | output | 2 | Reset scope code from the control word |
| ext_pulse | output | 1 | One-cycle external-pulse trigger on expiry |
| alt_boot | output | 1 | Latched alternate-boot selection (status bit 1) |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a keyed restart and an expiring tick. The bench provokes it by running the count down to zero, then driving tick_en and the key write in one cycle. It passes only if no reset or external pulse appears and the count reads back as the reload value. The second pair is a status clear and a flag being set: the bench raises an alternate-boot expiry in the very cycle that a clear is written, and expects alt_boot to remain high.

// File: rtl/tick_watchdog_pkg.sv
package tick_watchdog_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int THR_W   = 20;
  localparam int THR_LSB = DATA_W - THR_W;

  // byte offsets of the register slots
  localparam logic [ADDR_W-1:0] OFS_COUNT   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RELOAD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RESTART = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CLEAR   = 5'h14;

  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;

  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_RST   = 1;
  localparam int CB_IEN   = 2;
  localparam int CB_EXT   = 3;
  localparam int CB_SCOPE = 5;
  localparam int CB_ALT   = 7;

  // status word bit positions
  localparam int SB_ALT  = 1;
  localparam int SB_WARN = 2;
endpackage

// File: rtl/twd_regs.sv
module twd_regs
  import tick_watchdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] reload_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              kick_o,
  output logic              clr_o
);
  logic [DATA_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              wr_reload, wr_ctrl;

  always_comb begin
    wr_reload = bus_we && (bus_addr == OFS_RELOAD);
    wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
    kick_o    = bus_we && (bus_addr == OFS_RESTART) && (bus_wdata == RESTART_KEY);
    clr_o     = bus_we && (bus_addr == OFS_CLEAR) && bus_wdata[0];
    reload_d  = wr_reload ? bus_wdata : reload_q;
    ctrl_d    = wr_ctrl ? bus_wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
    end
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/twd_counter.sv
module twd_counter
  import tick_watchdog_pkg::*;
#(
  parameter int CW = DATA_W,
  parameter int TW = THR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          kick_i,
  input  logic [CW-1:0] reload_i,
  input  logic [TW-1:0] thr_i,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o,
  output logic          warn_hit_o
);
  localparam int PAD_W = CW - TW;

  logic [CW-1:0] cnt_q, cnt_d, thr_ext;
  logic          step;

  always_comb begin
    thr_ext    = {{PAD_W{1'b0}}, thr_i};
    step       = tick_i && en_i;
    cnt_d      = cnt_q;
    expire_o   = 1'b0;
    warn_hit_o = 1'b0;
    if (kick_i) begin
      cnt_d = reload_i;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_d    = reload_i;
        expire_o = 1'b1;
      end else begin
        cnt_d      = cnt_q - 1'b1;
        warn_hit_o = (cnt_d == thr_ext);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/twd_flags.sv
module twd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic warn_hit_i,
  input  logic clr_i,
  input  logic rst_en_i,
  input  logic ext_en_i,
  input  logic ien_i,
  input  logic alt_en_i,
  output logic warn_o,
  output logic alt_o,
  output logic rst_req_o,
  output logic ext_pulse_o
);
  logic warn_q, warn_d, alt_q, alt_d;
  logic rreq_q, rreq_d, ext_q, ext_d;

  always_comb begin
    warn_d = warn_q;
    alt_d  = alt_q;
    if (clr_i) begin
      warn_d = 1'b0;
      alt_d  = 1'b0;
    end
    // a set in the same cycle overrides the clear
    if (warn_hit_i && ien_i) warn_d = 1'b1;
    if (expire_i && alt_en_i) alt_d = 1'b1;
    rreq_d = expire_i && rst_en_i;
    ext_d  = expire_i && ext_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      alt_q  <= 1'b0;
      rreq_q <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      warn_q <= warn_d;
      alt_q  <= alt_d;
      rreq_q <= rreq_d;
      ext_q  <= ext_d;
    end
  end

  assign warn_o      = warn_q;
  assign alt_o       = alt_q;
  assign rst_req_o   = rreq_q;
  assign ext_pulse_o = ext_q;
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tick_watchdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_req,
  output logic [1:0]        rst_scope,
  output logic              ext_pulse,
  output logic              alt_boot
);
  logic [DATA_W-1:0] reload_w, ctrl_w, cnt_w, status_w;
  logic              kick_w, clr_w, expire_w, warn_hit_w, warn_w, alt_w;

  twd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .reload_o  (reload_w),
    .ctrl_o    (ctrl_w),
    .kick_o    (kick_w),
    .clr_o     (clr_w)
  );

  twd_counter #(.CW(DATA_W), .TW(THR_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_en),
    .en_i       (ctrl_w[CB_EN]),
    .kick_i     (kick_w),
    .reload_i   (reload_w),
    .thr_i      (ctrl_w[DATA_W-1:THR_LSB]),
    .cnt_o      (cnt_w),
    .expire_o   (expire_w),
    .warn_hit_o (warn_hit_w)
  );

  twd_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire_i    (expire_w),
    .warn_hit_i  (warn_hit_w),
    .clr_i       (clr_w),
    .rst_en_i    (ctrl_w[CB_RST]),
    .ext_en_i    (ctrl_w[CB_EXT]),
    .ien_i       (ctrl_w[CB_IEN]),
    .alt_en_i    (ctrl_w[CB_ALT]),
    .warn_o      (warn_w),
    .alt_o       (alt_w),
    .rst_req_o   (rst_req),
    .ext_pulse_o (ext_pulse)
  );

  always_comb begin
    status_w          = '0;
    status_w[SB_WARN] = warn_w;
    status_w[SB_ALT]  = alt_w;
    case (bus_addr)
      OFS_COUNT:  bus_rdata = cnt_w;
      OFS_RELOAD: bus_rdata = reload_w;
      OFS_CTRL:   bus_rdata = ctrl_w;
      OFS_STATUS: bus_rdata = status_w;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq       = warn_w;
  assign alt_boot  = alt_w;
  assign rst_scope = ctrl_w[CB_SCOPE+1:CB_SCOPE];
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk
  import tick_watchdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] reload,
  input logic              en,
  input logic              rst_en,
  input logic              ext_en,
  input logic              alt_en,
  input logic              rst_req,
  input logic              ext_pulse,
  input logic              alt_boot
);
  logic keyed;
  assign keyed = bus_we && (bus_addr == OFS_RESTART) && (bus_wdata == RESTART_KEY);

  // R2
  key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyed |=> cnt == $past(reload));

  // R3
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!keyed && !en) |=> $stable(cnt));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!keyed && en && tick_en && cnt != '0) |=> cnt == $past(cnt) - 1);

  // R4
  wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!keyed && en && tick_en && cnt == '0) |=> cnt == $past(reload));

  // R5
  rst_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(rst_en && en && tick_en && !keyed && cnt == '0));

  // R5
  ext_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |-> $past(ext_en && en && tick_en && !keyed && cnt == '0));

  // R8
  alt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alt_boot) |-> $past(alt_en));
endmodule

bind tick_watchdog tick_watchdog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .cnt       (cnt_w),
  .reload    (reload_w),
  .en        (ctrl_w[0]),
  .rst_en    (ctrl_w[1]),
  .ext_en    (ctrl_w[3]),
  .alt_en    (ctrl_w[7]),
  .rst_req   (rst_req),
  .ext_pulse (ext_pulse),
  .alt_boot  (alt_boot)
);

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req, ext_pulse, alt_boot;
  logic [1:0]  rst_scope;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [31:0] KEY = 32'h4755;

  always #4 clk = ~clk;

  tick_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req),
    .rst_scope(rst_scope), .ext_pulse(ext_pulse), .alt_boot(alt_boot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  // tick and a register write on the same clock edge
  task automatic tick_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    tick_en = 1'b1; bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v); chk("R1 count", v, 32'h0);
    rd(5'h04, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R1 ctrl", v, 32'h0);
    rd(5'h10, v); chk("R1 status", v, 32'h0);
    chk("R1 outputs", {28'h0, irq, rst_req, ext_pulse, alt_boot}, 32'h0);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(5'h04, 32'd5);
    rd(5'h00, v); chk("R11 count after reload write", v, 32'd0);
    wr(5'h08, 32'h1234);
    rd(5'h00, v); chk("R2 wrong key ignored", v, 32'd0);
    wr(5'h08, KEY);
    rd(5'h00, v); chk("R2 key loads count", v, 32'd5);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(5'h0C, 32'h1);
    tick1(); tick1();
    rd(5'h00, v); chk("R3 decrement", v, 32'd3);
    wr(5'h00, 32'd99);
    rd(5'h00, v); chk("R3 count write ignored", v, 32'd3);
    wr(5'h0C, 32'h0);
    tick1();
    rd(5'h00, v); chk("R3 frozen when disabled", v, 32'd3);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(5'h04, 32'd2); wr(5'h08, KEY);
    wr(5'h0C, 32'h2B); // enable, reset, external, scope full chip
    chk("R6 scope full chip", {30'h0, rst_scope}, 32'd1);
    tick1(); tick1();
    chk("R5 no pulse before expiry", {30'h0, rst_req, ext_pulse}, 32'd0);
    tick1();
    chk("R5 reset and external pulse", {30'h0, rst_req, ext_pulse}, 32'd3);
    rd(5'h00, v); chk("R4 reload on expiry", v, 32'd2);
    rd(5'h10, v); chk("R8 no alt flag without bit7", v, 32'd0);
    @(negedge clk);
    chk("R5 pulses last one cycle", {30'h0, rst_req, ext_pulse}, 32'd0);
    wr(5'h0C, 32'h01);
    tick1(); tick1(); tick1();
    chk("R5 pulses gated off", {30'h0, rst_req, ext_pulse}, 32'd0);
    rd(5'h00, v); chk("R4 second period", v, 32'd2);
  endtask

  task automatic t_scope();
    logic [31:0] v;
    wr(5'h04, 32'd4); wr(5'h08, KEY);
    wr(5'h0C, 32'h51); // enable, tick-source select, scope CPU
    rd(5'h0C, v); chk("R6 ctrl readback", v, 32'h51);
    chk("R6 scope cpu", {30'h0, rst_scope}, 32'd2);
    tick1();
    rd(5'h00, v); chk("R6 select bit no effect", v, 32'd3);
  endtask

  task automatic t_warn();
    logic [31:0] v;
    wr(5'h04, 32'd10); wr(5'h08, KEY);
    wr(5'h0C, 32'h7005); // threshold 7, irq enable, enable
    tick1(); tick1();
    chk("R7 no irq above threshold", {31'h0, irq}, 32'd0);
    tick1();
    chk("R7 irq at threshold", {31'h0, irq}, 32'd1);
    rd(5'h10, v); chk("R7 status warn bit", v, 32'h4);
    tick1();
    chk("R7 irq sticky", {31'h0, irq}, 32'd1);
    wr(5'h14, 32'h0);
    chk("R9 clear with bit0 low ignored", {31'h0, irq}, 32'd1);
    wr(5'h14, 32'h1);
    rd(5'h10, v); chk("R9 clear", {v[30:0], irq}, 32'd0);
    wr(5'h0C, 32'h7001);
    wr(5'h08, KEY);
    tick1(); tick1(); tick1();
    rd(5'h00, v); chk("R7 count at threshold", v, 32'd7);
    chk("R7 no irq when disabled", {31'h0, irq}, 32'd0);
  endtask

  task automatic t_alt();
    logic [31:0] v;
    wr(5'h04, 32'd1); wr(5'h08, KEY);
    wr(5'h0C, 32'h81);
    tick1();
    chk("R8 no alt before expiry", {31'h0, alt_boot}, 32'd0);
    tick1();
    chk("R8 alt boot set", {31'h0, alt_boot}, 32'd1);
    rd(5'h10, v); chk("R8 status alt bit", v, 32'h2);
    wr(5'h14, 32'h1);
    chk("R9 alt cleared", {31'h0, alt_boot}, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(5'h04, 32'd3); wr(5'h08, KEY);
    wr(5'h0C, 32'h8B);
    tick1(); tick1(); tick1();
    rd(5'h00, v); chk("R10 count at zero", v, 32'd0);
    tick_wr(5'h08, KEY);
    chk("R10 restart beats expiry", {29'h0, rst_req, ext_pulse, alt_boot}, 32'd0);
    rd(5'h00, v); chk("R10 count is reload", v, 32'd3);
    tick1(); tick1(); tick1();
    tick_wr(5'h14, 32'h1);
    chk("R9 set beats clear", {31'h0, alt_boot}, 32'd1);
    chk("R5 pulse in collision", {31'h0, rst_req}, 32'd1);
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_restart();
    t_count();
    t_expire();
    t_scope();
    t_warn();
    t_alt();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule